// File: doc/BRIEF.md
# Hysteretic Digital PLL Lock Detector

The block judges whether a phase-locked loop has settled. On each phase-detector cycle it measures how wide the phase-error pulse is. The error pulse is the logical OR of the charge-pump up and down requests. The width is counted in cycles of a fast sampling clock. A detector cycle ends when the combined pulse falls. A stretch of `IDLE_LIMIT` sampling cycles with no pulse counts as a detector cycle with zero error.

Lock needs a run of consecutive small errors. The run length is three or five, chosen by a mode input. Once lock is set, it holds until one cycle shows an error above a second, larger threshold. The gap between the two thresholds gives hysteresis. Both thresholds are inputs given in sampling-clock counts. For example, with a 1 GHz sampling clock, 15 ns and 25 ns become 15 and 25.

Top module: `pll_lock_detect`

## Requirements
- R1: While reset is asserted, and afterwards until a qualifying run completes, `lock_o` is low. A reset in the middle of a run discards the partial run.
- R2: The measured width is the number of sampling-clock edges at which `up_i | dn_i` is high. Overlapping or back-to-back up and down pulses merge into a single error pulse.
- R3: With `long_run_i` = 0, `lock_o` rises after three consecutive detector cycles with width strictly below `small_thr_i`. The rise happens at the first clock edge after the edge that first samples the combined pulse low at the end of the third cycle.
- R4: With `long_run_i` = 1, five such consecutive cycles are needed, with the same timing as R3.
- R5: While locked, one detector cycle with width strictly above `large_thr_i` clears `lock_o` at the same relative edge. A width equal to `large_thr_i` does not clear it.
- R6: A width from `small_thr_i` to `large_thr_i` inclusive leaves an existing lock in place. While unlocked, such a width restarts the run from zero. A width equal to `small_thr_i` is not small.
- R7: When no error pulse occurs for `IDLE_LIMIT` sampling edges, a zero-width detector cycle is counted. It is small whenever `small_thr_i` > 0.
- R8: A change of `long_run_i` while unlocked restarts the run count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| up_i | input | 1 | Charge-pump up request |
| dn_i | input | 1 | Charge-pump down request |
| long_run_i | input | 1 | 0: three good cycles to lock, 1: five |
| small_thr_i | input | CW | Width below which an error counts as small |
| large_thr_i | input | CW | Width above which an error drops the lock |
| lock_o | output | 1 | Active-high lock indication |

## Verification
A pulse is sampled into a register. Its end is seen one edge after the combined input is first sampled low, and the lock register changes on the edge after that. So every lock change is due one edge after the edge that samples the combined input low. An idle tick is due `IDLE_LIMIT` edges after the first low sample. The bench model keeps that one-edge delay as an explicit staged value. Inputs are driven on falling edges, the model steps on rising edges, and `lock_o` is compared against the model at every falling edge. That catches both early and late transitions. Named checks then confirm the settled state after each scenario, using values taken from the requirements alone.

// File: rtl/pld_pkg.sv
package pld_pkg;
  typedef enum logic [1:0] {
    ERR_SMALL = 2'd0,
    ERR_MID   = 2'd1,
    ERR_LARGE = 2'd2
  } err_cls_e;
endpackage

// File: rtl/pld_pulse_meter.sv
module pld_pulse_meter #(
  parameter int CW         = 8,
  parameter int IDLE_LIMIT = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          up_i,
  input  logic          dn_i,
  output logic          evt_o,
  output logic [CW-1:0] width_o
);
  localparam int IW = (IDLE_LIMIT > 2) ? $clog2(IDLE_LIMIT) : 1;
  localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_LIMIT - 1);
  localparam logic [CW-1:0] WID_MAX   = {CW{1'b1}};

  logic          err_q, err_d;
  logic [CW-1:0] wid_q, wid_d;
  logic [IW-1:0] idle_q, idle_d;
  logic          fall_evt, idle_evt;

  assign err_d    = up_i | dn_i;
  assign fall_evt = !err_q && (wid_q != '0);
  assign idle_evt = !err_q && (idle_q == IDLE_LAST);

  always_comb begin
    wid_d  = wid_q;
    idle_d = idle_q;
    if (err_q) begin
      if (wid_q != WID_MAX) wid_d = wid_q + CW'(1);
      idle_d = '0;
    end else begin
      wid_d = '0;
      if (idle_q == IDLE_LAST) idle_d = '0;
      else                     idle_d = idle_q + IW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      wid_q  <= '0;
      idle_q <= '0;
    end else begin
      err_q  <= err_d;
      wid_q  <= wid_d;
      idle_q <= idle_d;
    end
  end

  assign evt_o   = fall_evt | idle_evt;
  assign width_o = fall_evt ? wid_q : '0;

  // R2
  width_grows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> (wid_q != '0));

  // R7
  evt_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fall_evt, idle_evt}));

  // R2
  evt_after_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> !err_q);
endmodule

// File: rtl/pld_err_class.sv
module pld_err_class
  import pld_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic [CW-1:0] width_i,
  input  logic [CW-1:0] small_thr_i,
  input  logic [CW-1:0] large_thr_i,
  output err_cls_e      cls_o
);
  always_comb begin
    if (width_i < small_thr_i)      cls_o = ERR_SMALL;
    else if (width_i > large_thr_i) cls_o = ERR_LARGE;
    else                            cls_o = ERR_MID;
  end
endmodule

// File: rtl/pld_lock_fsm.sv
module pld_lock_fsm
  import pld_pkg::*;
#(
  parameter int RUN_SHORT = 3,
  parameter int RUN_LONG  = 5
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     evt_i,
  input  err_cls_e cls_i,
  input  logic     long_run_i,
  output logic     lock_o
);
  localparam int RMAX = (RUN_LONG > RUN_SHORT) ? RUN_LONG : RUN_SHORT;
  localparam int RW   = $clog2(RMAX + 1);

  logic          lock_q, lock_d;
  logic          mode_q;
  logic [RW-1:0] run_q, run_d, run_inc, need;

  assign need    = long_run_i ? RW'(RUN_LONG) : RW'(RUN_SHORT);
  assign run_inc = run_q + RW'(1);

  always_comb begin
    run_d  = run_q;
    lock_d = lock_q;
    if (!lock_q && (long_run_i != mode_q)) begin
      run_d = '0;
    end else if (evt_i) begin
      if (!lock_q) begin
        if (cls_i == ERR_SMALL) begin
          if (run_inc >= need) begin
            lock_d = 1'b1;
            run_d  = '0;
          end else begin
            run_d = run_inc;
          end
        end else begin
          run_d = '0;
        end
      end else if (cls_i == ERR_LARGE) begin
        lock_d = 1'b0;
        run_d  = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      run_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      lock_q <= lock_d;
      run_q  <= run_d;
      mode_q <= long_run_i;
    end
  end

  assign lock_o = lock_q;

  // R3
  rise_on_small_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(evt_i && (cls_i == ERR_SMALL)));

  // R5
  fall_on_large_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_q) |-> $past(evt_i && (cls_i == ERR_LARGE)));

  // R6
  hold_on_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && evt_i && (cls_i != ERR_LARGE)) |=> lock_q);

  // R4
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q < RW'(RMAX));

  // R8
  mode_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && (long_run_i != mode_q)) |=> (run_q == '0));
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
  import pld_pkg::*;
#(
  parameter int CW         = 8,
  parameter int IDLE_LIMIT = 64,
  parameter int RUN_SHORT  = 3,
  parameter int RUN_LONG   = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          up_i,
  input  logic          dn_i,
  input  logic          long_run_i,
  input  logic [CW-1:0] small_thr_i,
  input  logic [CW-1:0] large_thr_i,
  output logic          lock_o
);
  logic          rst_s1_q, rst_s2_q;
  logic          evt;
  logic [CW-1:0] width;
  err_cls_e      cls;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  pld_pulse_meter #(.CW(CW), .IDLE_LIMIT(IDLE_LIMIT)) u_meter (
    .clk_i  (clk_i),
    .rst_ni (rst_s2_q),
    .up_i   (up_i),
    .dn_i   (dn_i),
    .evt_o  (evt),
    .width_o(width)
  );

  pld_err_class #(.CW(CW)) u_class (
    .width_i    (width),
    .small_thr_i(small_thr_i),
    .large_thr_i(large_thr_i),
    .cls_o      (cls)
  );

  pld_lock_fsm #(.RUN_SHORT(RUN_SHORT), .RUN_LONG(RUN_LONG)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_s2_q),
    .evt_i     (evt),
    .cls_i     (cls),
    .long_run_i(long_run_i),
    .lock_o    (lock_o)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk_i)
    !rst_s2_q |=> !lock_o);
endmodule

// File: tb/pll_lock_detect_test.sv
module pll_lock_detect_test;
  localparam int CW = 8;
  localparam int IL = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          up, dn, mode;
  logic [CW-1:0] sthr, lthr;
  logic          lock;

  int    vecs  = 0;
  int    fails = 0;
  string cur_req = "R1";
  bit    finished = 0;

  always #10 clk = ~clk;

  pll_lock_detect #(.CW(CW), .IDLE_LIMIT(IL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .up_i(up), .dn_i(dn),
    .long_run_i(mode), .small_thr_i(sthr), .large_thr_i(lthr), .lock_o(lock)
  );

  // behavioural reference: counts, one staged decision per edge
  int m_rs, m_h, m_ic, m_run, m_w;
  bit m_lock, m_stg, m_pe, m_lm, m_old, m_e, m_evt;

  always @(posedge clk) begin
    if (!rst_n || m_rs < 2) begin
      if (!rst_n) m_rs = 0; else m_rs = m_rs + 1;
      m_lock = 0; m_stg = 0; m_h = 0; m_ic = 0; m_run = 0;
      m_pe = 0; m_lm = 0;
    end else begin
      m_old  = m_lock;
      m_lock = m_stg;
      m_e    = up | dn;
      if (mode != m_lm && !m_old) m_run = 0;
      m_lm = mode;
      if (m_pe) m_ic = 0;
      else if (m_ic == IL - 1) m_ic = 0;
      else m_ic = m_ic + 1;
      m_evt = 0;
      if (!m_e && m_h > 0) begin
        m_evt = 1; m_w = m_h; m_h = 0;
      end else if (m_e) begin
        if (m_h < 255) m_h = m_h + 1;
      end
      if (!m_e && !m_evt && m_ic == IL - 1) begin
        m_evt = 1; m_w = 0;
      end
      if (m_evt) begin
        if (!m_stg) begin
          if (m_w < int'(sthr)) begin
            m_run = m_run + 1;
            if (m_run >= (mode ? 5 : 3)) begin m_stg = 1; m_run = 0; end
          end else m_run = 0;
        end else if (m_w > int'(lthr)) begin
          m_stg = 0; m_run = 0;
        end
      end
      m_pe = m_e;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      vecs++;
      if (lock !== m_lock) begin
        fails++;
        $display("FAIL %s cycle-compare t=%0t lock_o=%0b expected=%0b",
                 cur_req, $time, lock, m_lock);
      end
    end
  end

  task automatic chk(input logic exp, input string req);
    vecs++;
    if (lock !== exp) begin
      fails++;
      $display("FAIL %s lock_o=%0b expected=%0b", req, lock, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int w, input bit use_dn, input int gap);
    @(negedge clk);
    if (use_dn) dn = 1; else up = 1;
    idle(w);
    up = 0; dn = 0;
    idle(gap);
  endtask

  task automatic burst(input int n, input int w);
    for (int i = 0; i < n; i++) pulse(w, i[0], 10);
  endtask

  initial begin
    up = 0; dn = 0; mode = 0; sthr = 8'd15; lthr = 8'd25; rst_n = 0;
    idle(3);
    chk(1'b0, "R1");
    rst_n = 1;
    idle(4);
    chk(1'b0, "R1");

    cur_req = "R3";
    burst(2, 5);
    chk(1'b0, "R3");
    pulse(5, 0, 10);
    chk(1'b1, "R3");

    cur_req = "R6";
    pulse(20, 1, 10);
    chk(1'b1, "R6");

    // R2: up 15 high, dn joins so the union is 26 wide
    cur_req = "R2";
    @(negedge clk); up = 1;
    idle(10); dn = 1;
    idle(5); up = 0;
    idle(11); dn = 0;
    idle(10);
    chk(1'b0, "R2");

    cur_req = "R6";
    burst(2, 4);
    pulse(18, 0, 10);
    burst(2, 4);
    chk(1'b0, "R6");
    pulse(4, 0, 10);
    chk(1'b1, "R6");

    cur_req = "R5";
    pulse(25, 0, 10);
    chk(1'b1, "R5");
    pulse(26, 1, 10);
    chk(1'b0, "R5");

    cur_req = "R6";
    burst(3, 15);
    chk(1'b0, "R6");
    burst(3, 14);
    chk(1'b1, "R6");
    pulse(30, 0, 10);

    cur_req = "R4";
    mode = 1;
    idle(10);
    burst(4, 6);
    chk(1'b0, "R4");
    pulse(6, 0, 10);
    chk(1'b1, "R4");
    pulse(40, 0, 10);
    chk(1'b0, "R5");

    cur_req = "R8";
    burst(3, 6);
    mode = 0;
    idle(10);
    burst(2, 6);
    chk(1'b0, "R8");
    pulse(6, 0, 10);
    chk(1'b1, "R8");
    pulse(30, 1, 2);

    cur_req = "R7";
    idle(2 * IL + 10);
    chk(1'b0, "R7");
    idle(IL);
    chk(1'b1, "R7");
    pulse(30, 0, 10);
    chk(1'b0, "R7");

    cur_req = "R1";
    burst(2, 5);
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(4);
    pulse(5, 0, 10);
    chk(1'b0, "R1");
    burst(2, 5);
    chk(1'b1, "R1");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    #3000000;
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired lock_o=%0b expected=end of sequence", lock);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule